// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block executes the data-movement instructions of a 16-bit word-addressed processor after fetch has already happened. On a `start` strobe it takes the instruction word and the incremented program counter, works out an effective address, and steps through one or two memory transactions. The memory is a single-port synchronous memory behind a request/ready handshake. An internal address register and data register sit between the sequencer and that memory.

The addressing modes are handled as follows:
- **PC-relative:** adds a signed 9-bit offset to the incremented PC.
- **Base+offset:** adds a signed 6-bit offset to a register-file value.
- **Indirect:** reads a pointer word at the PC-relative address, then uses that word as the address of the real access.
- **Address-only:** writes the PC-relative sum straight into a register without touching memory.

Loads write the fetched word back through a register-file write port and refresh a three-bit sign flag register. Stores route a register value into the data register before the write. A one-cycle `done` pulse marks completion.

Top module: `lsu_seq`

## Requirements
- R1: Opcode field instr[15:12] selects the operation: 0010 direct load, 0011 direct store, 1010 indirect load, 1011 indirect store, 0110 base load, 0111 base store, 1110 address-only. A `start` with any other opcode is ignored: no memory request, no register write, no `done`.
- R2: Direct load/store, and the pointer read of the indirect forms, use address `pc_in + sext(instr[8:0])`. Here `pc_in` is the already-incremented PC. For example, pc_in=x1481 with offset x09 gives x148A.
- R3: Indirect forms make exactly two memory accesses. The first is a read at the R2 address. The second uses the word returned by that read as its address.
- R4: Base forms present `instr[8:6]` on `rf_base_sel` and use address `rf_base_data + sext(instr[5:0])`, with exactly one memory access.
- R5: Address-only writes `pc_in + sext(instr[8:0])` to register `instr[11:9]` and raises no memory request.
- R6: Loads write the word returned by the final access into register `instr[11:9]`. The write is a single-cycle `rf_we`.
- R7: Stores present `instr[11:9]` on `rf_src_sel`. The final access carries `mem_we`=1 and `mem_wdata` equal to `rf_src_data`. Stores perform no register write.
- R8: While `mem_req` is high and `mem_ready` is low, the request and `mem_addr` stay unchanged.
- R9: `cc_nzp` holds {N,Z,P} and is exactly one-hot. It resets to 3'b010. Loads set it from the loaded word: bit 2 if negative, bit 1 if zero, bit 0 if positive. Stores and address-only leave it unchanged.
- R10: Each accepted instruction produces exactly one `done` pulse, one cycle wide, after its last memory access or register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| instr | input | 16 | Instruction word |
| pc_in | input | WORD_W | Incremented PC of the instruction |
| rf_base_sel | output | 3 | Register-file read select for the base register |
| rf_base_data | input | WORD_W | Base register value |
| rf_src_sel | output | 3 | Register-file read select for the store source |
| rf_src_data | input | WORD_W | Store source value |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_sel | output | 3 | Register-file write select |
| rf_wr_data | output | WORD_W | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | WORD_W | Memory address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory transaction complete |
| cc_nzp | output | 3 | Condition flags {N,Z,P} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default WORD_W of 16, so addresses wrap naturally at 16 bits. This brings in several checks that depend on that wrap:
- an address-only offset that crosses below zero;
- a base-plus-negative-offset sum;
- the sign of a loaded word with the top bit set.

The bench's memory model has an adjustable wait count from zero to several cycles. This exposes both the zero-wait path and request holding across stalls, including the stall between the two halves of an indirect access.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int INSTR_W  = 16;
    localparam int REG_SEL_W = 3;

    typedef enum logic [3:0] {
        OPC_LD  = 4'b0010,
        OPC_ST  = 4'b0011,
        OPC_LDI = 4'b1010,
        OPC_STI = 4'b1011,
        OPC_LDR = 4'b0110,
        OPC_STR = 4'b0111,
        OPC_LEA = 4'b1110
    } opc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR_RD,
        ST_PTR_MV,
        ST_ACCESS,
        ST_WB,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic valid;
        logic is_load;
        logic is_store;
        logic is_lea;
        logic indirect;
        logic base_mode;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [3:0] opc);
        op_dec_t d;
        d = '0;
        unique case (opc)
            OPC_LD:  begin d.valid = 1'b1; d.is_load  = 1'b1; end
            OPC_ST:  begin d.valid = 1'b1; d.is_store = 1'b1; end
            OPC_LDI: begin d.valid = 1'b1; d.is_load  = 1'b1; d.indirect = 1'b1; end
            OPC_STI: begin d.valid = 1'b1; d.is_store = 1'b1; d.indirect = 1'b1; end
            OPC_LDR: begin d.valid = 1'b1; d.is_load  = 1'b1; d.base_mode = 1'b1; end
            OPC_STR: begin d.valid = 1'b1; d.is_store = 1'b1; d.base_mode = 1'b1; end
            OPC_LEA: begin d.valid = 1'b1; d.is_lea   = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [INSTR_W-1:0] ir,
    input  logic [WORD_W-1:0]  pc,
    input  logic [WORD_W-1:0]  base,
    input  logic               base_mode,
    output logic [WORD_W-1:0]  ea
);
    localparam int OFF9_W = 9;
    localparam int OFF6_W = 6;

    logic [WORD_W-1:0] off9_x;
    logic [WORD_W-1:0] off6_x;

    assign off9_x = {{(WORD_W-OFF9_W){ir[OFF9_W-1]}}, ir[OFF9_W-1:0]};
    assign off6_x = {{(WORD_W-OFF6_W){ir[OFF6_W-1]}}, ir[OFF6_W-1:0]};

    always_comb begin
        if (base_mode) ea = base + off6_x;
        else           ea = pc + off9_x;
    end
endmodule

// File: rtl/lsu_flags.sv
module lsu_flags #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [WORD_W-1:0] value,
    output logic [2:0]        nzp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nzp <= 3'b010;
        end else if (upd) begin
            if (value[WORD_W-1])  nzp <= 3'b100;
            else if (value == '0) nzp <= 3'b010;
            else                  nzp <= 3'b001;
        end
    end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
    import lsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  op_dec_t    dec,
    input  logic       mem_ready,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_ADDR;
            ST_ADDR: begin
                if (dec.is_lea)        nxt = ST_WB;
                else if (dec.indirect) nxt = ST_PTR_RD;
                else                   nxt = ST_ACCESS;
            end
            ST_PTR_RD: if (mem_ready) nxt = ST_PTR_MV;
            ST_PTR_MV: nxt = ST_ACCESS;
            ST_ACCESS: if (mem_ready) nxt = dec.is_store ? ST_DONE : ST_WB;
            ST_WB:     nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
    import lsu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [WORD_W-1:0]    pc_in,
    output logic [REG_SEL_W-1:0] rf_base_sel,
    input  logic [WORD_W-1:0]    rf_base_data,
    output logic [REG_SEL_W-1:0] rf_src_sel,
    input  logic [WORD_W-1:0]    rf_src_data,
    output logic                 rf_we,
    output logic [REG_SEL_W-1:0] rf_wr_sel,
    output logic [WORD_W-1:0]    rf_wr_data,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WORD_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic [2:0]           cc_nzp,
    output logic                 done
);
    logic [INSTR_W-1:0] ir_q;
    logic [WORD_W-1:0]  pc_q;
    logic [WORD_W-1:0]  mar_q;
    logic [WORD_W-1:0]  mdr_q;
    logic [WORD_W-1:0]  ea;
    op_dec_t            dec_in;
    op_dec_t            dec_q;
    seq_state_t         state;
    logic               go;

    assign dec_in = decode_op(instr[15:12]);
    assign dec_q  = decode_op(ir_q[15:12]);
    assign go     = start && dec_in.valid;

    assign rf_base_sel = ir_q[8:6];
    assign rf_src_sel  = ir_q[11:9];
    assign rf_wr_sel   = ir_q[11:9];

    lsu_agen #(.WORD_W(WORD_W)) u_agen (
        .ir        (ir_q),
        .pc        (pc_q),
        .base      (rf_base_data),
        .base_mode (dec_q.base_mode),
        .ea        (ea)
    );

    lsu_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .dec       (dec_q),
        .mem_ready (mem_ready),
        .state     (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        ir_q <= instr;
                        pc_q <= pc_in;
                    end
                end
                ST_ADDR: begin
                    mar_q <= ea;
                    if (dec_q.is_store && !dec_q.indirect) mdr_q <= rf_src_data;
                end
                ST_PTR_RD: begin
                    if (mem_ready) mdr_q <= mem_rdata;
                end
                ST_PTR_MV: begin
                    mar_q <= mdr_q;
                    if (dec_q.is_store) mdr_q <= rf_src_data;
                end
                ST_ACCESS: begin
                    if (mem_ready && !dec_q.is_store) mdr_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    assign mem_req    = (state == ST_PTR_RD) || (state == ST_ACCESS);
    assign mem_we     = (state == ST_ACCESS) && dec_q.is_store;
    assign mem_addr   = mar_q;
    assign mem_wdata  = mdr_q;
    assign rf_we      = (state == ST_WB);
    assign rf_wr_data = dec_q.is_lea ? mar_q : mdr_q;
    assign done       = (state == ST_DONE);

    lsu_flags #(.WORD_W(WORD_W)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .upd   (rf_we && dec_q.is_load),
        .value (mdr_q),
        .nzp   (cc_nzp)
    );
endmodule

// File: rtl/lsu_seq_chk.sv
module lsu_seq_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rf_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic [2:0]        cc_nzp,
    input logic              done
);
    AST_HOLD_REQ_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R8
    AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req); // R7
    AST_FLAGS_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cc_nzp) == 1); // R9
    AST_FLAGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !rf_we |=> $stable(cc_nzp)); // R9
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_RF_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we); // R6
endmodule

bind lsu_seq lsu_seq_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rf_we     (rf_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .cc_nzp    (cc_nzp),
    .done      (done)
);

// File: tb/lsu_seq_tb.sv
module lsu_seq_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [15:0]  instr = '0;
    logic [W-1:0] pc_in = '0;
    logic [2:0]   rf_base_sel, rf_src_sel, rf_wr_sel;
    logic [W-1:0] rf_base_data, rf_src_data, rf_wr_data;
    logic         rf_we, mem_req, mem_we, done;
    logic [W-1:0] mem_addr, mem_wdata;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;
    logic [2:0]   cc_nzp;

    always #5 clk = ~clk;

    lsu_seq #(.WORD_W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_in(pc_in),
        .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
        .rf_src_sel(rf_src_sel), .rf_src_data(rf_src_data),
        .rf_we(rf_we), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .cc_nzp(cc_nzp), .done(done)
    );

    // Bench-owned register file and memory, written only by the test tasks
    logic [W-1:0] regs [0:7];
    logic [W-1:0] mem  [int];
    int lat = 0;

    assign rf_base_data = regs[rf_base_sel];
    assign rf_src_data  = regs[rf_src_sel];

    // Observation log
    int           n_acc = 0, n_rfw = 0, n_done = 0, wcnt = 0;
    bit           moved = 1'b0;
    logic [W-1:0] hold_addr = '0;
    logic [W-1:0] log_addr  [0:255];
    logic         log_we    [0:255];
    logic [W-1:0] log_wdata [0:255];
    logic [2:0]   last_wr_sel = '0;
    logic [W-1:0] last_wr_data = '0;

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            log_addr[n_acc]  <= mem_addr;
            log_we[n_acc]    <= mem_we;
            log_wdata[n_acc] <= mem_wdata;
            n_acc     <= n_acc + 1;
            mem_ready <= 1'b0;
        end else if (mem_req) begin
            if (wcnt != 0 && mem_addr != hold_addr) moved <= 1'b1;
            hold_addr <= mem_addr;
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
        if (rf_we) begin
            n_rfw        <= n_rfw + 1;
            last_wr_sel  <= rf_wr_sel;
            last_wr_data <= rf_wr_data;
        end
        if (done) n_done <= n_done + 1;
    end

    int n_chk = 0, n_fail = 0;
    int a0 = 0, r0 = 0, d0 = 0;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_instr(input logic [15:0] iw, input logic [W-1:0] pc);
        a0 = n_acc; r0 = n_rfw; d0 = n_done;
        @(negedge clk);
        start = 1'b1; instr = iw; pc_in = pc;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(done, "R10 done seen", {15'd0, done}, 16'd1);
        @(negedge clk);
        chk(!done && (n_done - d0) == 1, "R10 single pulse", 16'(n_done - d0), 16'd1);
    endtask

    task automatic t_reset();
        chk(!done && !mem_req && !rf_we, "R10 idle after reset", {13'd0, done, mem_req, rf_we}, 16'd0);
        chk(cc_nzp == 3'b010, "R9 reset flags", {13'd0, cc_nzp}, 16'h0002);
    endtask

    task automatic t_ld_pcrel();
        lat = 2; moved = 1'b0;
        mem[32'h148A] = 16'h8001;
        run_instr(16'h2609, 16'h1481);
        chk((n_acc - a0) == 1, "R2 one access", 16'(n_acc - a0), 16'd1);
        chk(log_addr[a0] == 16'h148A && !log_we[a0], "R2 address", log_addr[a0], 16'h148A);
        chk(last_wr_sel == 3'd3 && last_wr_data == 16'h8001, "R6 load writeback", last_wr_data, 16'h8001);
        chk(cc_nzp == 3'b100, "R9 negative flag", {13'd0, cc_nzp}, 16'h0004);
        chk(!moved, "R8 address held while stalled", {15'd0, moved}, 16'd0);
    endtask

    task automatic t_ld_negoff();
        lat = 0;
        mem[32'h00F0] = 16'h0000;
        run_instr(16'h23F0, 16'h0100);
        chk(log_addr[a0] == 16'h00F0, "R2 negative offset", log_addr[a0], 16'h00F0);
        chk(last_wr_sel == 3'd1 && last_wr_data == 16'h0000, "R6 zero load", last_wr_data, 16'h0000);
        chk(cc_nzp == 3'b010, "R9 zero flag", {13'd0, cc_nzp}, 16'h0002);
    endtask

    task automatic t_ldr();
        lat = 1;
        regs[5] = 16'h3000;
        mem[32'h2FFF] = 16'h0042;
        run_instr(16'h657F, 16'h7777);
        chk((n_acc - a0) == 1 && log_addr[a0] == 16'h2FFF, "R4 base minus one", log_addr[a0], 16'h2FFF);
        chk(last_wr_sel == 3'd2 && last_wr_data == 16'h0042, "R6 base load", last_wr_data, 16'h0042);
        chk(cc_nzp == 3'b001, "R9 positive flag", {13'd0, cc_nzp}, 16'h0001);
    endtask

    task automatic t_ldi();
        lat = 3; moved = 1'b0;
        mem[32'h2002] = 16'h5555;
        mem[32'h5555] = 16'hFFFF;
        run_instr(16'hA802, 16'h2000);
        chk((n_acc - a0) == 2, "R3 two accesses", 16'(n_acc - a0), 16'd2);
        chk(log_addr[a0] == 16'h2002, "R3 pointer address", log_addr[a0], 16'h2002);
        chk(log_addr[a0+1] == 16'h5555 && !log_we[a0+1], "R3 pointer used", log_addr[a0+1], 16'h5555);
        chk(last_wr_sel == 3'd4 && last_wr_data == 16'hFFFF, "R6 indirect load", last_wr_data, 16'hFFFF);
        chk(!moved, "R8 held across indirect stalls", {15'd0, moved}, 16'd0);
    endtask

    task automatic t_st();
        logic [2:0] cc0;
        lat = 1;
        cc0 = cc_nzp;
        regs[6] = 16'h1234;
        run_instr(16'h3DFF, 16'h4000);
        chk((n_acc - a0) == 1 && log_we[a0], "R7 write access", {15'd0, log_we[a0]}, 16'd1);
        chk(log_addr[a0] == 16'h3FFF && log_wdata[a0] == 16'h1234, "R7 store data", log_wdata[a0], 16'h1234);
        chk((n_rfw - r0) == 0, "R7 no register write", 16'(n_rfw - r0), 16'd0);
        chk(cc_nzp == cc0, "R9 store keeps flags", {13'd0, cc_nzp}, {13'd0, cc0});
    endtask

    task automatic t_str();
        lat = 0;
        regs[2] = 16'h0042;
        regs[1] = 16'h0000;
        run_instr(16'h7283, 16'h0001);
        chk(log_addr[a0] == 16'h0045 && log_we[a0], "R4 base store address", log_addr[a0], 16'h0045);
        chk(log_wdata[a0] == 16'h0000, "R7 base store data", log_wdata[a0], 16'h0000);
    endtask

    task automatic t_sti();
        lat = 2;
        mem[32'h0014] = 16'h0700;
        regs[0] = 16'hBEEF;
        run_instr(16'hB004, 16'h0010);
        chk((n_acc - a0) == 2 && !log_we[a0], "R3 indirect store read first", log_addr[a0], 16'h0014);
        chk(log_addr[a0+1] == 16'h0700 && log_we[a0+1], "R3 indirect store target", log_addr[a0+1], 16'h0700);
        chk(log_wdata[a0+1] == 16'hBEEF, "R7 indirect store data", log_wdata[a0+1], 16'hBEEF);
    endtask

    task automatic t_lea();
        logic [2:0] cc0;
        cc0 = cc_nzp;
        run_instr(16'hEB00, 16'h0005);
        chk((n_acc - a0) == 0, "R5 no memory access", 16'(n_acc - a0), 16'd0);
        chk(last_wr_sel == 3'd5 && last_wr_data == 16'hFF05, "R5 address written", last_wr_data, 16'hFF05);
        chk(cc_nzp == cc0, "R9 address-only keeps flags", {13'd0, cc_nzp}, {13'd0, cc0});
    endtask

    task automatic t_illegal();
        a0 = n_acc; r0 = n_rfw; d0 = n_done;
        @(negedge clk);
        start = 1'b1; instr = 16'h1000; pc_in = 16'h0100;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk((n_acc - a0) == 0 && !mem_req, "R1 no request", 16'(n_acc - a0), 16'd0);
        chk((n_rfw - r0) == 0 && (n_done - d0) == 0, "R1 no write or done", 16'(n_done - d0), 16'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ld_pcrel();
        t_ld_negoff();
        t_ldr();
        t_ldi();
        t_st();
        t_str();
        t_sti();
        t_lea();
        t_illegal();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule